// File: doc/BRIEF.md
# Voice Group Playback Sequencer

This block plays back one voice group at a time. A group is an ordered run of entries in a shared block table. Each entry names a fixed-size block of sample bytes, and the same block may be named by many groups, in any order. When a start request arrives with a 5-bit group number, the sequencer reads that group's first and last table entry from a pointer array. It then walks the entries in order. For each entry it reads the block number and streams every byte of that block, lowest offset first, out of the sample memory. The pointer array, the block table and the sample memory are external, and each is reached through a simple synchronous read port that returns data on the clock after the read strobe.

Samples leave the block on a valid/ready stream, at most one per sample tick. In 8-bit mode a byte is one sample. In 4-bit mode a byte carries two samples, and each is passed on zero-extended and undecoded. An optional ramp brackets the voice: a rising run of samples before it and a falling run after it. A stop request ends playback at once.

Back-pressure rules: one output slot holds the current sample. A tick copies the next sample into the slot only when a sample is staged and the slot is empty or is being drained in that cycle. Any other tick is simply unused. No sample is skipped or repeated, so back-pressure delays the stream but never changes its content. While `out_valid` is high and `out_ready` is low, the slot holds its value.

Top module: `voice_seq_top`

## Requirements
- R1: A start request seen while idle reads the pointer entry of `play_group`, and `busy` is high from the next cycle. A start request seen while busy is ignored, and the running group's stream is unchanged.
- R2: A pointer entry holds the first table entry in bits [9:0] and the last table entry in bits [19:10]. Entries from first to last inclusive are played. A group whose last entry is below its first entry is empty: it emits no sample and no ramp, and it finishes with a done pulse.
- R3: The sample address is {block number, byte offset}. Blocks are BLK_BYTES bytes long (512 by default). Each block is read at offsets 0 upward, and blocks are played in table order, repeats included.
- R4: With `fmt_nibble`=0, every byte is one sample, equal to the byte.
- R5: With `fmt_nibble`=1, every byte gives two samples: first {4'b0, bits [3:0]}, then {4'b0, bits [7:4]}.
- R6: With `ramp_on`=1, the voice is preceded by 128 samples of value i (i = 0..127) and followed by 256 samples of value (256-j)>>1 (j = 0..255). With `ramp_on`=0 there are no ramp samples.
- R7: `fmt_nibble` and `ramp_on` are captured when a start is accepted. Changing them during playback has no effect.
- R8: The output follows the back-pressure rules above. A new sample enters the slot only on a tick, and `out_data` stays stable while `out_valid` is high and `out_ready` is low.
- R9: `done` pulses for one clock after the last sample of the group has been taken downstream, and `busy` is already low in that cycle.
- R10: `play_stop` makes `busy` and `out_valid` low from the next cycle, discards pending samples and suppresses `done`. Stop takes priority over a start in the same cycle.
- R11: After reset, `busy`, `done` and `out_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| play_start | input | 1 | Start request |
| play_group | input | 5 | Group number for the start request |
| play_stop | input | 1 | Immediate stop |
| fmt_nibble | input | 1 | 1: two 4-bit samples per byte; 0: one 8-bit sample per byte |
| ramp_on | input | 1 | Enable the rising and falling ramps |
| tick | input | 1 | Sample tick |
| busy | output | 1 | Playback in progress |
| done | output | 1 | One-clock end-of-group pulse |
| ptr_rd | output | 1 | Pointer array read strobe |
| ptr_addr | output | 5 | Pointer array address |
| ptr_data | input | 20 | {last entry, first entry}, one cycle after the strobe |
| tbl_rd | output | 1 | Block table read strobe |
| tbl_addr | output | 10 | Block table address |
| tbl_data | input | 8 | Block number, one cycle after the strobe |
| smp_rd | output | 1 | Sample memory read strobe |
| smp_addr | output | 17 | {block, offset} |
| smp_data | input | 8 | Sample byte, one cycle after the strobe |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the sample |
| out_data | output | 8 | Output sample |

## Verification
A wrong internal state in this sequencer shows up as a changed sample stream rather than as a stuck pin. A wrong offset, entry index or nibble phase makes the very next handshaken sample differ from the byte the table and memory imply. A wrong ramp count or format capture lengthens or shortens the stream, and that is visible when `done` rises. The bench therefore compares every accepted sample, in order, against a stream built from the requirements, and checks the stream length at the `done` pulse. Handshake-hold, stop and done-pulse rules are watched on every cycle.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
  localparam int SMP_W = 8;
  localparam int NIB_W = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PTR,
    ST_RUP,
    ST_TBL,
    ST_TBLW,
    ST_SRD,
    ST_SW,
    ST_NIBH,
    ST_RDN,
    ST_FIN
  } vseq_state_e;
endpackage

// File: rtl/vseq_ramp.sv
module vseq_ramp #(
  parameter int UP_LEN = 128,
  parameter int DN_LEN = 256,
  parameter int MID    = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     step,
  input  logic                     dir_dn,
  output logic [vseq_pkg::SMP_W-1:0] val,
  output logic                     last
);
  localparam int MAXL = (UP_LEN > DN_LEN) ? UP_LEN : DN_LEN;
  localparam int CW   = $clog2(MAXL + 1);

  logic [CW-1:0] cnt_q;
  logic [31:0]   cnt32;
  logic [31:0]   num;
  logic [31:0]   den;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (step)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt32 = 32'(cnt_q);

  always_comb begin
    if (dir_dn) begin
      num = 32'(MID) * (32'(DN_LEN) - cnt32);
      den = 32'(DN_LEN);
    end else begin
      num = 32'(MID) * cnt32;
      den = 32'(UP_LEN);
    end
    val  = vseq_pkg::SMP_W'(num / den);
    last = dir_dn ? (cnt32 == 32'(DN_LEN - 1)) : (cnt32 == 32'(UP_LEN - 1));
  end
endmodule

// File: rtl/vseq_outreg.sv
module vseq_outreg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          tick,
  input  logic          stg_valid,
  input  logic [DW-1:0] stg_data,
  output logic          take,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready
);
  assign take = tick && stg_valid && (!out_valid || out_ready) && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (flush) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= stg_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/vseq_walk.sv
module vseq_walk
  import vseq_pkg::*;
#(
  parameter int NGRP      = 32,
  parameter int TBL_DEPTH = 960,
  parameter int NBLK      = 252,
  parameter int BLK_BYTES = 512,
  localparam int GW = $clog2(NGRP),
  localparam int EW = $clog2(TBL_DEPTH),
  localparam int BW = $clog2(NBLK),
  localparam int OW = $clog2(BLK_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [GW-1:0]    grp,
  input  logic             stop,
  input  logic             fmt_nib,
  input  logic             ramp_en,
  output logic             ptr_rd,
  output logic [GW-1:0]    ptr_addr,
  input  logic [2*EW-1:0]  ptr_data,
  output logic             tbl_rd,
  output logic [EW-1:0]    tbl_addr,
  input  logic [BW-1:0]    tbl_data,
  output logic             smp_rd,
  output logic [BW+OW-1:0] smp_addr,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             take,
  input  logic             out_busy,
  output logic             stg_valid,
  output logic [SMP_W-1:0] stg_data,
  output logic             rmp_clr,
  output logic             rmp_step,
  output logic             rmp_dir,
  input  logic [SMP_W-1:0] rmp_val,
  input  logic             rmp_last,
  output logic             busy,
  output logic             done
);
  localparam logic [OW-1:0] OFF_LAST = OW'(BLK_BYTES - 1);

  vseq_state_e       st_q, st_after;
  logic [EW-1:0]     ent_q, last_q;
  logic [BW-1:0]     blk_q;
  logic [OW-1:0]     off_q;
  logic [SMP_W-1:0]  byte_q;
  logic              nib_q, rmp_q, done_q;
  logic              stg_free, blk_end, grp_end;
  logic [EW-1:0]     p_first, p_last;

  assign p_first  = ptr_data[EW-1:0];
  assign p_last   = ptr_data[2*EW-1:EW];
  assign stg_free = !stg_valid || take;
  assign blk_end  = (off_q == OFF_LAST);
  assign grp_end  = (ent_q == last_q);

  always_comb begin
    if (!blk_end)     st_after = ST_SRD;
    else if (!grp_end) st_after = ST_TBL;
    else if (rmp_q)   st_after = ST_RDN;
    else              st_after = ST_FIN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      ent_q     <= '0;
      last_q    <= '0;
      blk_q     <= '0;
      off_q     <= '0;
      byte_q    <= '0;
      nib_q     <= 1'b0;
      rmp_q     <= 1'b0;
      done_q    <= 1'b0;
      stg_valid <= 1'b0;
      stg_data  <= '0;
    end else begin
      done_q <= 1'b0;
      if (take) stg_valid <= 1'b0;
      if (stop) begin
        st_q      <= ST_IDLE;
        stg_valid <= 1'b0;
      end else begin
        unique case (st_q)
          ST_IDLE: if (start) begin
            nib_q <= fmt_nib;
            rmp_q <= ramp_en;
            st_q  <= ST_PTR;
          end
          ST_PTR: begin
            ent_q  <= p_first;
            last_q <= p_last;
            if (p_last < p_first) st_q <= ST_FIN;
            else if (rmp_q)       st_q <= ST_RUP;
            else                  st_q <= ST_TBL;
          end
          ST_RUP: if (stg_free) begin
            stg_valid <= 1'b1;
            stg_data  <= rmp_val;
            if (rmp_last) st_q <= ST_TBL;
          end
          ST_TBL:  st_q <= ST_TBLW;
          ST_TBLW: begin
            blk_q <= tbl_data;
            off_q <= '0;
            st_q  <= ST_SRD;
          end
          ST_SRD: if (stg_free) st_q <= ST_SW;
          ST_SW: begin
            stg_valid <= 1'b1;
            byte_q    <= smp_data;
            if (nib_q) begin
              stg_data <= {{(SMP_W-NIB_W){1'b0}}, smp_data[NIB_W-1:0]};
              st_q     <= ST_NIBH;
            end else begin
              stg_data <= smp_data;
              st_q     <= st_after;
              if (!blk_end)      off_q <= off_q + 1'b1;
              else if (!grp_end) ent_q <= ent_q + 1'b1;
            end
          end
          ST_NIBH: if (stg_free) begin
            stg_valid <= 1'b1;
            stg_data  <= {{(SMP_W-NIB_W){1'b0}}, byte_q[SMP_W-1:NIB_W]};
            st_q      <= st_after;
            if (!blk_end)      off_q <= off_q + 1'b1;
            else if (!grp_end) ent_q <= ent_q + 1'b1;
          end
          ST_RDN: if (stg_free) begin
            stg_valid <= 1'b1;
            stg_data  <= rmp_val;
            if (rmp_last) st_q <= ST_FIN;
          end
          ST_FIN: if (!stg_valid && !out_busy) begin
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign ptr_rd   = (st_q == ST_IDLE) && start && !stop;
  assign ptr_addr = grp;
  assign tbl_rd   = (st_q == ST_TBL);
  assign tbl_addr = ent_q;
  assign smp_rd   = (st_q == ST_SRD) && stg_free;
  assign smp_addr = {blk_q, off_q};
  assign rmp_dir  = (st_q == ST_RDN);
  assign rmp_step = ((st_q == ST_RUP) || (st_q == ST_RDN)) && stg_free;
  assign rmp_clr  = !((st_q == ST_RUP) || (st_q == ST_RDN));
  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
endmodule

// File: rtl/voice_seq_top.sv
module voice_seq_top #(
  parameter int NGRP      = 32,
  parameter int TBL_DEPTH = 960,
  parameter int NBLK      = 252,
  parameter int BLK_BYTES = 512,
  parameter int RAMP_UP   = 128,
  parameter int RAMP_DN   = 256,
  parameter int MID_LEVEL = 128,
  localparam int GW = $clog2(NGRP),
  localparam int EW = $clog2(TBL_DEPTH),
  localparam int BW = $clog2(NBLK),
  localparam int OW = $clog2(BLK_BYTES),
  localparam int DW = vseq_pkg::SMP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             play_start,
  input  logic [GW-1:0]    play_group,
  input  logic             play_stop,
  input  logic             fmt_nibble,
  input  logic             ramp_on,
  input  logic             tick,
  output logic             busy,
  output logic             done,
  output logic             ptr_rd,
  output logic [GW-1:0]    ptr_addr,
  input  logic [2*EW-1:0]  ptr_data,
  output logic             tbl_rd,
  output logic [EW-1:0]    tbl_addr,
  input  logic [BW-1:0]    tbl_data,
  output logic             smp_rd,
  output logic [BW+OW-1:0] smp_addr,
  input  logic [DW-1:0]    smp_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data
);
  logic          take, stg_valid;
  logic [DW-1:0] stg_data, rmp_val;
  logic          rmp_clr, rmp_step, rmp_dir, rmp_last;

  vseq_walk #(
    .NGRP(NGRP), .TBL_DEPTH(TBL_DEPTH), .NBLK(NBLK), .BLK_BYTES(BLK_BYTES)
  ) walk_i (
    .clk(clk), .rst_n(rst_n),
    .start(play_start), .grp(play_group), .stop(play_stop),
    .fmt_nib(fmt_nibble), .ramp_en(ramp_on),
    .ptr_rd(ptr_rd), .ptr_addr(ptr_addr), .ptr_data(ptr_data),
    .tbl_rd(tbl_rd), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .smp_rd(smp_rd), .smp_addr(smp_addr), .smp_data(smp_data),
    .take(take), .out_busy(out_valid),
    .stg_valid(stg_valid), .stg_data(stg_data),
    .rmp_clr(rmp_clr), .rmp_step(rmp_step), .rmp_dir(rmp_dir),
    .rmp_val(rmp_val), .rmp_last(rmp_last),
    .busy(busy), .done(done)
  );

  vseq_ramp #(
    .UP_LEN(RAMP_UP), .DN_LEN(RAMP_DN), .MID(MID_LEVEL)
  ) ramp_i (
    .clk(clk), .rst_n(rst_n), .clr(rmp_clr), .step(rmp_step),
    .dir_dn(rmp_dir), .val(rmp_val), .last(rmp_last)
  );

  vseq_outreg #(.DW(DW)) oreg_i (
    .clk(clk), .rst_n(rst_n), .flush(play_stop), .tick(tick),
    .stg_valid(stg_valid), .stg_data(stg_data), .take(take),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );
endmodule

// File: rtl/vseq_chk.sv
module vseq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          stop,
  input logic          tick,
  input logic          busy,
  input logic          done,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data
);
  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !stop) |=> busy);

  p_hold_stream_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !stop) |=> (out_valid && $stable(out_data)));

  p_load_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !tick) |=> !out_valid);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_stop_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!busy && !out_valid && !done));
endmodule

bind voice_seq_top vseq_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(play_start), .stop(play_stop),
  .tick(tick), .busy(busy), .done(done), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data)
);

// File: tb/voice_seq_top_tb_top.sv
`timescale 1ns/1ps
module voice_seq_top_tb_top;
  localparam int BLK = 32;
  localparam int EW  = 10;
  localparam int BW  = 8;
  localparam int OW  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic play_start = 1'b0, play_stop = 1'b0, fmt_nibble = 1'b0, ramp_on = 1'b0;
  logic [4:0] play_group = '0;
  logic tick = 1'b0, out_ready = 1'b0;
  logic busy, done, ptr_rd, tbl_rd, smp_rd, out_valid;
  logic [4:0] ptr_addr;
  logic [2*EW-1:0] ptr_data = '0;
  logic [EW-1:0] tbl_addr;
  logic [BW-1:0] tbl_data = '0;
  logic [BW+OW-1:0] smp_addr;
  logic [7:0] smp_data = '0, out_data;

  logic [2*EW-1:0] ptr_mem [32];
  logic [BW-1:0]   tbl_mem [960];

  int tests = 0, fails = 0, cyc = 0, tcnt = 0;
  int done_cnt = 0, d0 = 0, hold_chk = 0, hold_err = 0, done_err = 0;
  logic [7:0] got[$];
  logic [7:0] exp[$];
  logic prev_v = 0, prev_r = 0, prev_s = 0, prev_done = 0;
  logic [7:0] prev_d = '0;

  always #2 clk = ~clk;

  voice_seq_top #(.BLK_BYTES(BLK)) dut_i (
    .clk(clk), .rst_n(rst_n), .play_start(play_start), .play_group(play_group),
    .play_stop(play_stop), .fmt_nibble(fmt_nibble), .ramp_on(ramp_on), .tick(tick),
    .busy(busy), .done(done), .ptr_rd(ptr_rd), .ptr_addr(ptr_addr), .ptr_data(ptr_data),
    .tbl_rd(tbl_rd), .tbl_addr(tbl_addr), .tbl_data(tbl_data), .smp_rd(smp_rd),
    .smp_addr(smp_addr), .smp_data(smp_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [7:0] smp_fn(input logic [BW+OW-1:0] a);
    return 8'(32'(a) * 13 + (32'(a) >> 5) * 7 + 29);
  endfunction

  // memory models: data one cycle after the strobe
  always @(posedge clk) begin
    if (ptr_rd) ptr_data <= ptr_mem[ptr_addr];
    if (tbl_rd) tbl_data <= tbl_mem[tbl_addr];
    if (smp_rd) smp_data <= smp_fn(smp_addr);
  end

  // tick every 4 clocks, random back-pressure
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    tick <= (tcnt == 0);
    tcnt <= (tcnt == 3) ? 0 : tcnt + 1;
    out_ready <= (($urandom % 4) != 0);
  end

  // monitor away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_v && !prev_r && !prev_s) begin
        hold_chk++;
        if (!(out_valid && out_data == prev_d)) hold_err++;
      end
      if (out_valid && out_ready) got.push_back(out_data);
      if (done) begin
        done_cnt++;
        if (busy || prev_done) done_err++;
      end
      prev_v = out_valid; prev_r = out_ready; prev_d = out_data;
      prev_s = play_stop; prev_done = done;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic build_exp(input int g, input bit nib, input bit rmp);
    int s, e;
    s = int'(ptr_mem[g][EW-1:0]);
    e = int'(ptr_mem[g][2*EW-1:EW]);
    exp.delete();
    if (e < s) return;
    if (rmp) for (int i = 0; i < 128; i++) exp.push_back(8'(i));
    for (int ent = s; ent <= e; ent++) begin
      for (int off = 0; off < BLK; off++) begin
        logic [7:0] b;
        b = smp_fn({tbl_mem[ent], OW'(off)});
        if (nib) begin
          exp.push_back({4'b0, b[3:0]});
          exp.push_back({4'b0, b[7:4]});
        end else exp.push_back(b);
      end
    end
    if (rmp) for (int j = 0; j < 256; j++) exp.push_back(8'((256 - j) >> 1));
  endtask

  task automatic launch(input int g, input bit nib, input bit rmp);
    build_exp(g, nib, rmp);
    got.delete();
    d0 = done_cnt;
    @(posedge clk); #1;
    play_group = 5'(g); fmt_nibble = nib; ramp_on = rmp; play_start = 1'b1;
    @(posedge clk); #1;
    play_start = 1'b0;
    @(negedge clk);
    if (exp.size() != 0) check(busy == 1'b1, "R1 busy after start", int'(busy), 1);
  endtask

  task automatic finish(input string tag);
    int wd = 0;
    int bad = -1;
    while (done_cnt == d0 && wd < 60000) begin
      @(negedge clk);
      wd++;
    end
    check(wd < 60000, {tag, " done seen (R9)"}, wd, 0);
    check(got.size() == exp.size(), {tag, " length"}, got.size(), exp.size());
    for (int k = 0; k < got.size() && k < exp.size(); k++)
      if (bad < 0 && got[k] != exp[k]) bad = k;
    if (bad >= 0) check(1'b0, {tag, " sample"}, int'(got[bad]), int'(exp[bad]));
    else check(1'b1, {tag, " sample"}, 0, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 960; i++) tbl_mem[i] = BW'($urandom % 252);
    for (int g = 0; g < 32; g++) begin
      int s, l;
      s = 1 + int'($urandom % 940);
      l = int'($urandom % 3);
      ptr_mem[g] = {EW'(s + l - 1), EW'(s)};
    end
    // directed groups
    for (int i = 0; i < 13; i++) tbl_mem[20 + i] = BW'(i);
    for (int i = 0; i < 3; i++)  tbl_mem[40 + i] = BW'(13 + i);
    for (int i = 0; i < 13; i++) tbl_mem[43 + i] = BW'(i);
    tbl_mem[959] = BW'(251);
    ptr_mem[0] = {EW'(32), EW'(20)};
    ptr_mem[1] = {EW'(55), EW'(40)};
    ptr_mem[2] = {EW'(4), EW'(5)};
    ptr_mem[3] = {EW'(959), EW'(959)};

    repeat (5) @(posedge clk);
    @(negedge clk);
    check(!busy && !out_valid && !done, "R11 reset state", int'({busy, out_valid, done}), 0);
    @(posedge clk); #1 rst_n = 1'b1;

    launch(0, 0, 0); finish("R3 R4 pcm group0");
    launch(1, 1, 0); finish("R3 R5 nibble reused blocks");
    launch(0, 0, 1); finish("R6 pcm with ramp");
    launch(2, 0, 1); finish("R2 empty group");
    launch(3, 1, 1); finish("R6 last entry last block");

    // R1 R7: start and setting changes while busy are ignored
    launch(0, 0, 0);
    repeat (120) @(posedge clk);
    #1; fmt_nibble = 1'b1; ramp_on = 1'b1; play_group = 5'd1; play_start = 1'b1;
    @(posedge clk); #1 play_start = 1'b0;
    finish("R1 R7 start while busy");

    // R10: stop mid-play
    launch(1, 1, 1);
    repeat (300) @(posedge clk);
    #1 play_stop = 1'b1;
    @(posedge clk); #1 play_stop = 1'b0;
    @(negedge clk);
    check(!busy && !out_valid, "R10 stop clears", int'({busy, out_valid}), 0);
    repeat (40) @(negedge clk);
    check(done_cnt == d0, "R10 no done after stop", done_cnt, d0);
    // R10: stop wins over start
    @(posedge clk); #1 play_stop = 1'b1; play_start = 1'b1; play_group = 5'd0;
    @(posedge clk); #1 play_stop = 1'b0; play_start = 1'b0;
    @(negedge clk);
    check(!busy, "R10 stop over start", int'(busy), 0);

    // random groups and modes
    for (int n = 0; n < 8; n++) begin
      int g;
      g = 4 + int'($urandom % 28);
      launch(g, 1'($urandom % 2), 1'($urandom % 2));
      finish("R2 R5 R6 random group");
    end

    check(hold_err == 0 && hold_chk > 0, "R8 hold while not ready", hold_err, 0);
    check(done_err == 0, "R9 done single and idle", done_err, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(negedge clk) begin
    if (cyc > 190000) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule